// File: doc/BRIEF.md
# Indirect Register Window for a Network Controller

This block is the register front end a host uses to drive a network controller over a plain 32-bit I/O port. Internal registers are not decoded one per address. The host first writes a register index to an address port. A data port then reads or writes the control register at that index. A second data port does the same for bus-configuration registers, using the same index. The station address is readable directly at the bottom of the I/O window. Reading a dedicated offset puts every register back into its reset state.

Register index 0 holds the main command/status word. Its command bits are one-shot strobes towards the controller's engines: start initialisation, start, stop and transmit demand. Its status flags are set by event inputs from those engines and are cleared by the host writing 1 to them. It also reports an error summary, an interrupt summary and a run state. Other registers hold the initialisation-block address, an interrupt mask, a feature word and a fixed identification value. The ring engines are outside this block and appear only as strobes and event pulses.

The block's flops take an asynchronous active-low reset, which is released in step with the clock.

Top module: `nic_csr_file`

## Requirements
- R1: The I/O byte offsets decode as follows: 0x00 returns the low 32 bits of STATION_ADDR, 0x04 returns its upper 16 bits in data bits [15:0], 0x10 is the register data port, 0x14 is the 7-bit index port (it reads back the index, upper written bits dropped) and 0x1C is the bus-configuration data port.
- R2: After hardware reset, register 0 reads 0x0004, and the run outputs and irq_o are 0. Register 0 bit layout: 0 init, 1 start, 2 stop, 3 transmit demand, 4 tx on, 5 rx on, 6 interrupt enable, 7 interrupt summary, 8 init done, 9 tx done, 10 rx done, 11 memory error, 12 missed frame, 13 collision, 14 babble, 15 error summary. Bits 0, 1 and 3 read as 0.
- R3: A read at offset 0x18 returns 0. It restores the reset state of every register: register 0 reads 0x0004, the index is 0, and registers 1 to 4 and the bus-configuration register are 0.
- R4: Writing 1 to any of register 0 bits 14..8 clears that flag. Writing 0 leaves it unchanged. Flags never clear any other way except reset.
- R5: Register 0 bit 15 reads as the OR of bits 14, 13, 12 and 11.
- R6: A write with start set and stop clear sets tx on and rx on and clears stop. A write with stop set clears both run bits and sets stop, whatever else is written.
- R7: A write with init set (and stop clear) clears stop and pulses init_start_o for one cycle, in the cycle after the write. A write with transmit demand set pulses tx_demand_o the same way. The ev_init_done input sets bit 8.
- R8: Bit 7 is the OR of the flags in bits 14..8 whose mask bit in register 3 (same bit positions) is 0. irq_o is 1 exactly when bit 7 and bit 6 are both 1.
- R9: Registers 1 and 2 hold the low and high halves of init_blk_addr_o. Register 4 holds feature_o. Register 3 stores only bits 14..8; its other bits read 0.
- R10: Registers 88 and 89 return the low and high 16 bits of CHIP_ID, and writes to them have no effect.
- R11: With index CFG_IDX (default 20), the bus-configuration port reads and writes a 16-bit register driven on bus_cfg_o. Any other index on that port reads 0 and ignores writes.
- R12: Register indices not listed here read 0 and ignore writes. Misaligned offsets (address bits [1:0] not 0) read 0 and have no effect. Data bits 31..16 of the data ports read 0.
- R13: When an event input and a write-1 clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 5 | I/O byte offset |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data for io_addr (combinational) |
| ev_init_done | input | 1 | Initialisation finished pulse |
| ev_tx_done | input | 1 | Transmit finished pulse |
| ev_rx_done | input | 1 | Receive finished pulse |
| ev_mem_err | input | 1 | Memory error pulse |
| ev_rx_miss | input | 1 | Missed frame pulse |
| ev_collision | input | 1 | Collision error pulse |
| ev_babble | input | 1 | Transmitter babble pulse |
| init_start_o | output | 1 | One-cycle initialisation strobe |
| tx_demand_o | output | 1 | One-cycle transmit poll strobe |
| tx_on_o | output | 1 | Transmitter running |
| rx_on_o | output | 1 | Receiver running |
| irq_o | output | 1 | Interrupt request |
| init_blk_addr_o | output | 32 | Initialisation-block address |
| feature_o | output | 16 | Feature register contents |
| bus_cfg_o | output | 16 | Bus-configuration register contents |

## Verification
Directed sequences drive each command on its own, then stop together with start. These show whether stop takes priority, whether the strobes land one cycle after the write, and whether a zero write disturbs any flag. An event pulse arrives in the same cycle as a clear of the same flag, to show which one wins. Random mixes of event pulses, command/clear writes and mask writes are checked against a bench model after every read of register 0 and of irq_o. These mixes reveal mistakes in the error summary, in the masked interrupt summary and in the enable gating. Reads of unknown indices, misaligned offsets and the reset offset show whether stray accesses leave state untouched and whether a read reset restores every register.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int IO_W     = 32;
  localparam int REG_W    = 16;
  localparam int RAP_W    = 7;
  localparam int NFLAG    = 7;
  localparam int FLAG_LSB = 8;

  // I/O window, dword index = byte offset >> 2
  localparam logic [2:0] PORT_PROM_LO = 3'd0;
  localparam logic [2:0] PORT_PROM_HI = 3'd1;
  localparam logic [2:0] PORT_RDP     = 3'd4;
  localparam logic [2:0] PORT_RAP     = 3'd5;
  localparam logic [2:0] PORT_SRST    = 3'd6;
  localparam logic [2:0] PORT_BDP     = 3'd7;

  // register 0 command / state bit positions
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_IENA = 6;

  // register indices
  localparam int IDX_CMD    = 0;
  localparam int IDX_IBA_LO = 1;
  localparam int IDX_IBA_HI = 2;
  localparam int IDX_MASK   = 3;
  localparam int IDX_FEAT   = 4;
endpackage

// File: rtl/nic_csr0_ctl.sv
module nic_csr0_ctl
  import nic_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic [NFLAG-1:0] ev_set,
  input  logic [NFLAG-1:0] mask,
  output logic [REG_W-1:0] csr0_rd,
  output logic             init_start_o,
  output logic             tx_demand_o,
  output logic             tx_on_o,
  output logic             rx_on_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flags_q, flags_d;
  logic iena_q, iena_d, txon_q, txon_d, rxon_q, rxon_d, stop_q, stop_d;
  logic init_q, init_d, tdmd_q, tdmd_d;
  logic intr, err;

  always_comb begin
    flags_d = flags_q | ev_set;
    iena_d  = iena_q;
    txon_d  = txon_q;
    rxon_d  = rxon_q;
    stop_d  = stop_q;
    init_d  = 1'b0;
    tdmd_d  = 1'b0;
    if (srst) begin
      flags_d = '0;
      iena_d  = 1'b0;
      txon_d  = 1'b0;
      rxon_d  = 1'b0;
      stop_d  = 1'b1;
    end else if (wr_en) begin
      flags_d = (flags_q & ~wdata[FLAG_LSB +: NFLAG]) | ev_set;
      iena_d  = wdata[B_IENA];
      tdmd_d  = wdata[B_TDMD];
      if (wdata[B_STOP]) begin
        stop_d = 1'b1;
        txon_d = 1'b0;
        rxon_d = 1'b0;
      end else begin
        init_d = wdata[B_INIT];
        if (wdata[B_STRT]) begin
          txon_d = 1'b1;
          rxon_d = 1'b1;
        end
        if (wdata[B_STRT] | wdata[B_INIT]) stop_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      iena_q  <= 1'b0;
      txon_q  <= 1'b0;
      rxon_q  <= 1'b0;
      stop_q  <= 1'b1;
      init_q  <= 1'b0;
      tdmd_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      iena_q  <= iena_d;
      txon_q  <= txon_d;
      rxon_q  <= rxon_d;
      stop_q  <= stop_d;
      init_q  <= init_d;
      tdmd_q  <= tdmd_d;
    end
  end

  assign intr = |(flags_q & ~mask);
  assign err  = |flags_q[NFLAG-1:NFLAG-4];
  assign csr0_rd = {err, flags_q, intr, iena_q, rxon_q, txon_q, 1'b0, stop_q, 1'b0, 1'b0};
  assign init_start_o = init_q;
  assign tx_demand_o  = tdmd_q;
  assign tx_on_o      = txon_q;
  assign rx_on_o      = rxon_q;
  assign irq_o        = intr & iena_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !srst && wdata[FLAG_LSB+1] && !ev_set[1]) |=> !csr0_rd[FLAG_LSB+1]); // R4
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !srst) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set[2] && !srst) |=> csr0_rd[FLAG_LSB+2]); // R13
  AST_STRT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !srst && wdata[B_STRT] && !wdata[B_STOP]) |=> (tx_on_o && rx_on_o && !csr0_rd[B_STOP])); // R6
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !srst && wdata[B_STOP]) |=> (!tx_on_o && !rx_on_o && csr0_rd[B_STOP])); // R6
  AST_SRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (csr0_rd == 16'h0004)); // R3
  AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !srst && wdata[B_INIT] && !wdata[B_STOP]) |=> init_start_o); // R7
endmodule

// File: rtl/nic_csr_regs.sv
module nic_csr_regs
  import nic_csr_pkg::*;
#(
  parameter logic [31:0] CHIP_ID   = 32'h1A57_0C41,
  parameter int          ID_LO_IDX = 88,
  parameter int          ID_HI_IDX = 89,
  parameter int          CFG_IDX   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             rap_wr,
  input  logic             rdp_wr,
  input  logic             bdp_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] csr0_rd,
  output logic [RAP_W-1:0] rap_o,
  output logic [REG_W-1:0] rdp_rd,
  output logic [REG_W-1:0] bdp_rd,
  output logic [NFLAG-1:0] mask_o,
  output logic [31:0]      iblk_addr_o,
  output logic [REG_W-1:0] feature_o,
  output logic [REG_W-1:0] bus_cfg_o
);
  logic [RAP_W-1:0] rap_q, rap_d;
  logic [REG_W-1:0] iba_lo_q, iba_lo_d, iba_hi_q, iba_hi_d, feat_q, feat_d, cfg_q, cfg_d;
  logic [NFLAG-1:0] mask_q, mask_d;
  logic             cfg_sel;

  assign cfg_sel = (rap_q == RAP_W'(CFG_IDX));

  always_comb begin
    rap_d    = rap_q;
    iba_lo_d = iba_lo_q;
    iba_hi_d = iba_hi_q;
    feat_d   = feat_q;
    cfg_d    = cfg_q;
    mask_d   = mask_q;
    if (srst) begin
      rap_d    = '0;
      iba_lo_d = '0;
      iba_hi_d = '0;
      feat_d   = '0;
      cfg_d    = '0;
      mask_d   = '0;
    end else begin
      if (rap_wr) rap_d = wdata[RAP_W-1:0];
      if (rdp_wr) begin
        if (rap_q == RAP_W'(IDX_IBA_LO)) iba_lo_d = wdata;
        if (rap_q == RAP_W'(IDX_IBA_HI)) iba_hi_d = wdata;
        if (rap_q == RAP_W'(IDX_MASK))   mask_d   = wdata[FLAG_LSB +: NFLAG];
        if (rap_q == RAP_W'(IDX_FEAT))   feat_d   = wdata;
      end
      if (bdp_wr && cfg_sel) cfg_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rap_q    <= '0;
      iba_lo_q <= '0;
      iba_hi_q <= '0;
      feat_q   <= '0;
      cfg_q    <= '0;
      mask_q   <= '0;
    end else begin
      rap_q    <= rap_d;
      iba_lo_q <= iba_lo_d;
      iba_hi_q <= iba_hi_d;
      feat_q   <= feat_d;
      cfg_q    <= cfg_d;
      mask_q   <= mask_d;
    end
  end

  always_comb begin
    rdp_rd = '0;
    if (rap_q == RAP_W'(IDX_CMD))    rdp_rd = csr0_rd;
    if (rap_q == RAP_W'(IDX_IBA_LO)) rdp_rd = iba_lo_q;
    if (rap_q == RAP_W'(IDX_IBA_HI)) rdp_rd = iba_hi_q;
    if (rap_q == RAP_W'(IDX_MASK))   rdp_rd = {1'b0, mask_q, {FLAG_LSB{1'b0}}};
    if (rap_q == RAP_W'(IDX_FEAT))   rdp_rd = feat_q;
    if (rap_q == RAP_W'(ID_LO_IDX))  rdp_rd = CHIP_ID[15:0];
    if (rap_q == RAP_W'(ID_HI_IDX))  rdp_rd = CHIP_ID[31:16];
  end

  assign bdp_rd      = cfg_sel ? cfg_q : '0;
  assign rap_o       = rap_q;
  assign mask_o      = mask_q;
  assign iblk_addr_o = {iba_hi_q, iba_lo_q};
  assign feature_o   = feat_q;
  assign bus_cfg_o   = cfg_q;

  AST_RAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rap_wr && !srst) |=> $stable(rap_q)); // R1
  AST_IBA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdp_wr && !srst && rap_q == RAP_W'(IDX_IBA_LO)) |=> (iblk_addr_o[15:0] == $past(wdata))); // R9
  AST_CFG_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bdp_wr && cfg_sel) && !srst) |=> $stable(bus_cfg_o)); // R11
endmodule

// File: rtl/nic_csr_file.sv
module nic_csr_file
  import nic_csr_pkg::*;
#(
  parameter logic [47:0] STATION_ADDR = 48'h4A3B_2C1D_0EF5,
  parameter logic [31:0] CHIP_ID      = 32'h1A57_0C41,
  parameter int          CFG_IDX      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       io_addr,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [IO_W-1:0]  io_wdata,
  output logic [IO_W-1:0]  io_rdata,
  input  logic             ev_init_done,
  input  logic             ev_tx_done,
  input  logic             ev_rx_done,
  input  logic             ev_mem_err,
  input  logic             ev_rx_miss,
  input  logic             ev_collision,
  input  logic             ev_babble,
  output logic             init_start_o,
  output logic             tx_demand_o,
  output logic             tx_on_o,
  output logic             rx_on_o,
  output logic             irq_o,
  output logic [31:0]      init_blk_addr_o,
  output logic [REG_W-1:0] feature_o,
  output logic [REG_W-1:0] bus_cfg_o
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             aligned, srst, rap_wr, rdp_wr, bdp_wr, cmd_wr;
  logic [2:0]       port;
  logic [RAP_W-1:0] rap;
  logic [REG_W-1:0] csr0_rd, rdp_rd, bdp_rd;
  logic [NFLAG-1:0] mask, ev_vec;
  logic             unused_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign aligned = (io_addr[1:0] == 2'b00);
  assign port    = io_addr[4:2];
  assign srst    = io_rd & aligned & (port == PORT_SRST);
  assign rap_wr  = io_wr & aligned & (port == PORT_RAP);
  assign rdp_wr  = io_wr & aligned & (port == PORT_RDP);
  assign bdp_wr  = io_wr & aligned & (port == PORT_BDP);
  assign cmd_wr  = rdp_wr & (rap == RAP_W'(IDX_CMD));
  assign ev_vec  = {ev_babble, ev_collision, ev_rx_miss, ev_mem_err,
                    ev_rx_done, ev_tx_done, ev_init_done};
  assign unused_hi = ^io_wdata[IO_W-1:REG_W];

  nic_csr0_ctl u_cmd (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .srst         (srst),
    .wr_en        (cmd_wr),
    .wdata        (io_wdata[REG_W-1:0]),
    .ev_set       (ev_vec),
    .mask         (mask),
    .csr0_rd      (csr0_rd),
    .init_start_o (init_start_o),
    .tx_demand_o  (tx_demand_o),
    .tx_on_o      (tx_on_o),
    .rx_on_o      (rx_on_o),
    .irq_o        (irq_o)
  );

  nic_csr_regs #(.CHIP_ID(CHIP_ID), .CFG_IDX(CFG_IDX)) u_regs (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .srst        (srst),
    .rap_wr      (rap_wr),
    .rdp_wr      (rdp_wr),
    .bdp_wr      (bdp_wr),
    .wdata       (io_wdata[REG_W-1:0]),
    .csr0_rd     (csr0_rd),
    .rap_o       (rap),
    .rdp_rd      (rdp_rd),
    .bdp_rd      (bdp_rd),
    .mask_o      (mask),
    .iblk_addr_o (init_blk_addr_o),
    .feature_o   (feature_o),
    .bus_cfg_o   (bus_cfg_o)
  );

  always_comb begin
    io_rdata = '0;
    if (aligned) begin
      case (port)
        PORT_PROM_LO: io_rdata = STATION_ADDR[31:0];
        PORT_PROM_HI: io_rdata = {{(IO_W-16){1'b0}}, STATION_ADDR[47:32]};
        PORT_RDP:     io_rdata = {{(IO_W-REG_W){1'b0}}, rdp_rd};
        PORT_RAP:     io_rdata = {{(IO_W-RAP_W){1'b0}}, rap};
        PORT_BDP:     io_rdata = {{(IO_W-REG_W){1'b0}}, bdp_rd};
        default:      io_rdata = '0;
      endcase
    end
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!core_rst_n)
    irq_o |-> (|csr0_rd[FLAG_LSB +: NFLAG])); // R8
endmodule

// File: tb/nic_csr_file_tb.sv
module nic_csr_file_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [47:0] TB_MAC = 48'h4A3B_2C1D_0EF5;
  localparam logic [31:0] TB_ID  = 32'h1A57_0C41;
  localparam logic [4:0]  A_PROM0 = 5'h00, A_PROM1 = 5'h04, A_RDP = 5'h10,
                          A_RAP = 5'h14, A_SRST = 5'h18, A_BDP = 5'h1C;

  logic        clk, rst_n, io_rd, io_wr;
  logic [4:0]  io_addr;
  logic [31:0] io_wdata, io_rdata, init_blk_addr_o;
  logic [6:0]  ev;
  logic        init_start_o, tx_demand_o, tx_on_o, rx_on_o, irq_o;
  logic [15:0] feature_o, bus_cfg_o;

  int n_chk, n_fail;
  logic [6:0] m_flags, m_mask;
  logic m_iena, m_tx, m_rx, m_stop;

  nic_csr_file #(.STATION_ADDR(TB_MAC), .CHIP_ID(TB_ID), .CFG_IDX(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ev_init_done(ev[0]), .ev_tx_done(ev[1]), .ev_rx_done(ev[2]), .ev_mem_err(ev[3]),
    .ev_rx_miss(ev[4]), .ev_collision(ev[5]), .ev_babble(ev[6]),
    .init_start_o(init_start_o), .tx_demand_o(tx_demand_o), .tx_on_o(tx_on_o),
    .rx_on_o(rx_on_o), .irq_o(irq_o), .init_blk_addr_o(init_blk_addr_o),
    .feature_o(feature_o), .bus_cfg_o(bus_cfg_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_csr0();
    logic intr;
    intr = |(m_flags & ~m_mask);
    return {|m_flags[6:3], m_flags, intr, m_iena, m_rx, m_tx, 1'b0, m_stop, 2'b00};
  endfunction

  function automatic logic exp_irq();
    return (|(m_flags & ~m_mask)) & m_iena;
  endfunction

  task automatic mdl_reset();
    m_flags = '0; m_mask = '0; m_iena = 0; m_tx = 0; m_rx = 0; m_stop = 1;
  endtask

  task automatic mdl_write(input logic [15:0] d, input logic [6:0] set);
    m_flags = (m_flags & ~d[14:8]) | set;
    m_iena  = d[6];
    if (d[2]) begin m_stop = 1; m_tx = 0; m_rx = 0; end
    else begin
      if (d[1]) begin m_tx = 1; m_rx = 1; end
      if (d[1] | d[0]) m_stop = 0;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic rd_csr(input int idx, output logic [31:0] d);
    wr(A_RAP, idx);
    rd(A_RDP, d);
  endtask

  task automatic wr_csr(input int idx, input logic [31:0] d);
    wr(A_RAP, idx);
    wr(A_RDP, d);
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
    m_flags = m_flags | v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] got;
    n_chk = 0; n_fail = 0;
    rst_n = 0; io_rd = 0; io_wr = 0; io_addr = '0; io_wdata = '0; ev = '0;
    void'($urandom(32'd20240703));
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R2 reset state
    rd(A_RDP, got);           chk("R2 csr0 reset", got, 32'h0004);
    chk("R2 run/irq reset", {tx_on_o, rx_on_o, irq_o}, 0);

    // R1 window decode
    rd(A_PROM0, got);         chk("R1 prom low", got, TB_MAC[31:0]);
    rd(A_PROM1, got);         chk("R1 prom high", got, {16'h0, TB_MAC[47:32]});
    wr(A_RAP, 32'h5A);        rd(A_RAP, got); chk("R1 index readback", got, 32'h5A);
    wr(A_RAP, 32'hFFFF_FFFF); rd(A_RAP, got); chk("R1 index width", got, 32'h7F);

    // R9 storage registers
    wr_csr(1, 32'hFFFF_1234); wr_csr(2, 32'h0000_ABCD);
    chk("R9 init block addr", init_blk_addr_o, 32'hABCD_1234);
    rd_csr(1, got);           chk("R9 csr1 readback", got, 32'h1234);
    wr_csr(4, 32'hBEEF);      chk("R9 feature out", feature_o, 16'hBEEF);
    wr_csr(3, 32'hFFFF);      rd_csr(3, got); chk("R9 mask bits only", got, 32'h7F00);
    wr_csr(3, 32'h0);

    // R10 identification
    rd_csr(88, got);          chk("R10 id low", got, {16'h0, TB_ID[15:0]});
    wr(A_RDP, 32'h0);         rd(A_RDP, got); chk("R10 id write ignored", got, {16'h0, TB_ID[15:0]});
    rd_csr(89, got);          chk("R10 id high", got, {16'h0, TB_ID[31:16]});

    // R11 bus configuration
    wr(A_RAP, 20); wr(A_BDP, 32'h0002); rd(A_BDP, got); chk("R11 cfg readback", got, 32'h0002);
    wr(A_RAP, 21); wr(A_BDP, 32'h5555); rd(A_BDP, got); chk("R11 other index reads 0", got, 0);
    chk("R11 other index write ignored", bus_cfg_o, 16'h0002);

    // R12 unimplemented / misaligned
    wr_csr(50, 32'hFFFF);     rd(A_RDP, got); chk("R12 unimpl reads 0", got, 0);
    rd(5'h11, got);           chk("R12 misaligned read", got, 0);
    wr(5'h15, 32'h1);         rd(A_RAP, got); chk("R12 misaligned write", got, 32'd50);
    rd_csr(0, got);           chk("R12 csr0 untouched", got, {16'h0, exp_csr0()});

    // R6 start / stop
    wr_csr(0, 32'h0002); mdl_write(16'h0002, 0);
    rd(A_RDP, got);      chk("R6 start", got, {16'h0, exp_csr0()});
    chk("R6 run outputs", {tx_on_o, rx_on_o}, 2'b11);
    wr(A_RDP, 32'h0006); mdl_write(16'h0006, 0);
    rd(A_RDP, got);      chk("R6 stop wins", got, {16'h0, exp_csr0()});

    // R7 init strobe and done flag
    wr(A_RDP, 32'h0041); mdl_write(16'h0041, 0);
    chk("R7 init pulse high", init_start_o, 1);
    @(negedge clk);      chk("R7 init pulse one cycle", init_start_o, 0);
    pulse(7'h01);
    rd(A_RDP, got);      chk("R7 idon set", got, {16'h0, exp_csr0()});
    chk("R8 irq asserted", irq_o, 1);

    // R4 write one clears, write zero holds
    wr(A_RDP, 32'h0100); mdl_write(16'h0100, 0);
    rd(A_RDP, got);      chk("R4 w1c", got, {16'h0, exp_csr0()});
    pulse(7'h08);
    rd(A_RDP, got);      chk("R5 err summary", got, {16'h0, exp_csr0()});
    wr(A_RDP, 32'h0000); mdl_write(16'h0000, 0);
    rd(A_RDP, got);      chk("R4 write zero holds", got, {16'h0, exp_csr0()});

    // R8 mask
    wr_csr(3, 32'h0800); m_mask = 7'h08;
    rd_csr(0, got);      chk("R8 masked intr", got, {16'h0, exp_csr0()});

    // R7 transmit demand
    wr(A_RDP, 32'h0008); mdl_write(16'h0008, 0);
    chk("R7 tdmd pulse", tx_demand_o, 1);

    // R13 set beats clear
    @(negedge clk); io_addr = A_RDP; io_wdata = 32'h0200; io_wr = 1; ev = 7'h02;
    @(negedge clk); io_wr = 0; ev = '0;
    mdl_write(16'h0200, 7'h02);
    rd(A_RDP, got);      chk("R13 event wins", got, {16'h0, exp_csr0()});

    // R3 read-triggered reset
    wr_csr(0, 32'h0042); wr(A_RAP, 4);
    rd(A_SRST, got);     chk("R3 reset port reads 0", got, 0);
    mdl_reset();
    rd(A_RAP, got);      chk("R3 index cleared", got, 0);
    rd(A_RDP, got);      chk("R3 csr0 after reset", got, 32'h0004);
    chk("R3 regs cleared", {init_blk_addr_o, feature_o, bus_cfg_o}, 64'h0);
    chk("R3 run cleared", {tx_on_o, rx_on_o, irq_o}, 0);

    // random mix, R4 R5 R8 against model
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 3);
      d  = $urandom;
      case (op)
        0: pulse(d[6:0]);
        1: begin d = d & 32'h7F47; wr_csr(0, d); mdl_write(d[15:0], 0); end
        2: begin wr_csr(3, d); m_mask = d[14:8]; end
        default: begin
          rd_csr(0, got);
          chk("R8/R5/R4 random csr0", got, {16'h0, exp_csr0()});
          chk("R8 random irq", irq_o, exp_irq());
        end
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule